// File: doc/BRIEF.md
# Processor Trace Status and Address Nibble Port

This block drives the real-time trace pins of a processor core. Every clock it shows a 4-bit status code for the instruction stream on `pst` and a 4-bit data nibble on `ddata`. When the core reports an instruction that carries an address to show, typically a taken indirect branch, the block builds a group of one size marker followed by the low address nibbles. It loads the whole group into a 16-entry nibble queue. The queue drains onto `ddata` at one nibble per clock.

Status and data are separate streams. The status pins carry on with later instructions while earlier address nibbles are still leaving the data pins. If a new group does not fit in the queue, the block raises `stall` to hold the core's pipeline and shows status 0x0 until enough entries have drained. A two-bit setting chooses how many address bytes are shown, or switches address capture off. The reset input is asynchronous and active low. It is expected to be released in step with `clk`.

Top module: `trace_port`

## Requirements
- R1: While reset is low and after it is released, `pst` = 0x0, `ddata` = 0x0, `stall` = 0 and the queue is empty.
- R2: An event that is accepted (`evt_valid` high and `stall` low) appears on `pst` one clock later. A cycle with no accepted event shows 0x0 on `pst`.
- R3: A captured group goes out on `ddata` in this order: the marker nibble first, then the address nibbles from least significant to most significant. Each nibble is shown for one clock.
- R4: `cfg_show` = 1 shows 2 bytes with marker 0x9 and 4 address nibbles. `cfg_show` = 2 shows 3 bytes with marker 0xA and 6 address nibbles. `cfg_show` = 3 shows 4 bytes with marker 0xB and 8 address nibbles.
- R5: With `cfg_show` = 0, an event with `evt_capture` high is accepted like any other. It never stalls and puts nothing on `ddata`.
- R6: When the queue is empty, `ddata` is 0x0.
- R7: A capturing event whose group needs more entries than are free raises `stall` in the same cycle, combinationally. Nothing from it is queued, and `pst` shows 0x0 on the next clock. The group is accepted in the first cycle in which it fits. Free space is counted before that cycle's drain.
- R8: Events without capture are never stalled. Their status reaches `pst` while queued nibbles are still draining.
- R9: Groups drain in the order they were accepted, with no gap between them and no nibble lost. The queue never holds more than 16 nibbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | An instruction status event is presented |
| evt_pst | input | 4 | Status code for the event (0x5 is a taken branch) |
| evt_capture | input | 1 | The event carries an address to show |
| evt_addr | input | 32 | Address to show for the event |
| cfg_show | input | 2 | Address bytes shown: 0 off, 1/2/3 means 2/3/4 bytes |
| stall | output | 1 | Holds the core pipeline; the event is not accepted |
| pst | output | 4 | Registered status nibble |
| ddata | output | 4 | Registered data nibble |

## Verification
The hardest case to reach from the ports is a capture arriving when the queue is almost full. The stall must then depend on the exact free count before that cycle's drain, and the group must be taken in the very cycle it first fits. The stimulus sends 4-byte branch groups back to back and 2-byte groups right behind them. The held event is then retried every clock while the bench checks the stall against its own count of queued nibbles. Status-only events are slipped in during the drain to show that the two streams are independent.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int NIB_W     = 4;
  localparam int MAX_BYTES = 4;
  localparam int MAX_NIBS  = 1 + 2 * MAX_BYTES;
  localparam int LANE_W    = $clog2(MAX_NIBS + 1);

  typedef logic [NIB_W-1:0] nib_t;
  typedef nib_t [MAX_NIBS-1:0] group_t;

  localparam nib_t MARK_BASE = 4'h8;

  function automatic nib_t size_marker(input logic [1:0] sel);
    return MARK_BASE + nib_t'(sel);
  endfunction

  function automatic logic [LANE_W-1:0] group_len(input logic [1:0] sel);
    return LANE_W'(2 * int'(sel) + 3);
  endfunction
endpackage

// File: rtl/trace_group_build.sv
module trace_group_build
  import trace_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        show_sel,
  output group_t            lanes,
  output logic [LANE_W-1:0] lane_cnt,
  output logic              show_on
);
  localparam int ADDR_NIBS = ADDR_W / NIB_W;

  always_comb begin
    show_on  = (show_sel != 2'd0);
    lane_cnt = show_on ? group_len(show_sel) : '0;
  end

  assign lanes[0] = size_marker(show_sel);

  generate
    for (genvar l = 1; l < MAX_NIBS; l++) begin : g_lane
      if (l - 1 < ADDR_NIBS) begin : g_addr
        assign lanes[l] = addr[NIB_W*(l-1) +: NIB_W];
      end else begin : g_pad
        assign lanes[l] = '0;
      end
    end
  endgenerate
endmodule

// File: rtl/trace_nib_fifo.sv
module trace_nib_fifo
  import trace_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [LANE_W-1:0]            push_n,
  input  group_t                       lanes,
  output logic [$clog2(DEPTH+1)-1:0]   free_cnt,
  output nib_t                         dout
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  nib_t          dout_q, dout_d;
  nib_t          mem [DEPTH];
  logic          pop;

  assign pop      = (cnt_q != '0);
  assign free_cnt = CW'(DEPTH) - cnt_q;
  assign dout     = dout_q;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    dout_d   = '0;
    if (push) begin
      wr_ptr_d = wr_ptr_q + PW'(push_n);
      cnt_d    = cnt_d + CW'(push_n);
    end
    if (pop) begin
      rd_ptr_d = rd_ptr_q + PW'(1);
      cnt_d    = cnt_d - CW'(1);
      dout_d   = mem[rd_ptr_q];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      dout_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      dout_q   <= dout_d;
    end
  end

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic [PW-1:0] off;
      logic          hit;
      nib_t          wdat;
      always_comb begin
        off  = PW'(e) - wr_ptr_q;
        hit  = push && (CW'(off) < CW'(push_n));
        wdat = (int'(off) < MAX_NIBS) ? lanes[off] : '0;
      end
      always_ff @(posedge clk) begin
        if (hit) mem[e] <= wdat;
      end
    end
  endgenerate

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (free_cnt >= CW'(push_n)));
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |=> (dout_q == '0));
endmodule

// File: rtl/trace_pst_ctrl.sv
module trace_pst_ctrl
  import trace_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt_valid,
  input  nib_t evt_pst,
  input  logic want_cap,
  input  logic room_ok,
  output logic stall,
  output logic push,
  output nib_t pst
);
  nib_t pst_q, pst_d;
  logic accept;

  always_comb begin
    stall  = evt_valid && want_cap && !room_ok;
    accept = evt_valid && !stall;
    push   = accept && want_cap;
    pst_d  = accept ? evt_pst : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pst_q <= '0;
    else        pst_q <= pst_d;
  end

  assign pst = pst_q;

  a_r7_stall_shows_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (pst == '0));
  a_r7_no_push_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !push);
  a_r2_status_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !stall) |=> (pst == $past(evt_pst)));
  a_r8_plain_never_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !want_cap) |-> !stall);
endmodule

// File: rtl/trace_port.sv
module trace_port
  import trace_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [3:0]        evt_pst,
  input  logic              evt_capture,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [1:0]        cfg_show,
  output logic              stall,
  output logic [3:0]        pst,
  output logic [3:0]        ddata
);
  localparam int CW = $clog2(DEPTH + 1);

  group_t            lanes;
  logic [LANE_W-1:0] lane_cnt;
  logic              show_on;
  logic [CW-1:0]     free_cnt;
  logic              want_cap;
  logic              room_ok;
  logic              push;

  trace_group_build #(.ADDR_W(ADDR_W)) u_build (
    .addr     (evt_addr),
    .show_sel (cfg_show),
    .lanes    (lanes),
    .lane_cnt (lane_cnt),
    .show_on  (show_on)
  );

  always_comb begin
    want_cap = evt_capture && show_on;
    room_ok  = (free_cnt >= CW'(lane_cnt));
  end

  trace_pst_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_pst   (evt_pst),
    .want_cap  (want_cap),
    .room_ok   (room_ok),
    .stall     (stall),
    .push      (push),
    .pst       (pst)
  );

  trace_nib_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_n   (lane_cnt),
    .lanes    (lanes),
    .free_cnt (free_cnt),
    .dout     (ddata)
  );

  a_r5_off_never_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_show == 2'd0) |-> !stall);
endmodule

// File: tb/sim_trace_port.sv
module sim_trace_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_valid;
  logic [3:0]  evt_pst;
  logic        evt_capture;
  logic [31:0] evt_addr;
  logic [1:0]  cfg_show;
  logic        stall;
  logic [3:0]  pst;
  logic [3:0]  ddata;

  int errors = 0;
  int checks = 0;
  bit mon_on = 1'b0;
  bit done   = 1'b0;
  logic [3:0] exp_q[$];
  logic [3:0] stage_q[$];
  logic [3:0] stage_pst = 4'h0;

  always #10 clk = ~clk;

  trace_port u0 (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_pst(evt_pst),
    .evt_capture(evt_capture), .evt_addr(evt_addr), .cfg_show(cfg_show),
    .stall(stall), .pst(pst), .ddata(ddata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: compares DDATA and PST, then moves staged expectations in
  always @(negedge clk) begin
    if (mon_on) begin
      if (exp_q.size() > 0) begin
        logic [3:0] e;
        e = exp_q.pop_front();
        check(ddata == e, "R3", ddata, e);
      end else begin
        check(ddata == 4'h0, "R6", ddata, 0);
      end
      check(pst == stage_pst, "R2", pst, stage_pst);
      foreach (stage_q[i]) exp_q.push_back(stage_q[i]);
      stage_q.delete();
      stage_pst = 4'h0;
    end
  end

  function automatic int need_of(input logic [1:0] c);
    return 2 * c + 3;
  endfunction

  // driver: presents one event, retrying every clock while stalled
  task automatic send(input logic [3:0] st, input bit cap, input logic [31:0] a);
    bit taken = 0;
    while (!taken) begin
      bit es;
      @(negedge clk);
      evt_valid = 1'b1; evt_pst = st; evt_capture = cap; evt_addr = a;
      #1;
      es = cap && (cfg_show != 0) && ((16 - exp_q.size()) < need_of(cfg_show));
      check(stall == es, "R7", stall, es);
      if (!stall) begin
        taken = 1;
        stage_pst = st;
        if (cap && cfg_show != 0) begin
          stage_q.push_back(4'h8 + 4'(cfg_show));
          for (int n = 0; n < 2 * (cfg_show + 1); n++)
            stage_q.push_back(a[4*n +: 4]);
        end
      end
    end
    @(negedge clk);
    evt_valid = 1'b0; evt_capture = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      evt_valid = 1'b0; evt_capture = 1'b0;
    end
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt_valid = 1'b0; evt_pst = 4'h0; evt_capture = 1'b0;
    evt_addr = '0; cfg_show = 2'd1;
    repeat (3) @(negedge clk);
    check(pst == 0 && ddata == 0 && stall == 0, "R1", {pst, ddata, 3'b0, stall}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pst == 0 && ddata == 0, "R1", {pst, ddata}, 0);
    mon_on = 1'b1;

    // R2 plain status codes
    send(4'h1, 0, 32'h0); send(4'h2, 0, 32'h0); send(4'hF, 0, 32'h0);
    // R3 R4 2-byte capture, marker 0x9
    cfg_show = 2'd1;
    send(4'h5, 1, 32'h1234_ABCD);
    idle(8);
    // R4 3-byte (0xA) and 4-byte (0xB)
    cfg_show = 2'd2; send(4'h5, 1, 32'h0076_5432); idle(9);
    cfg_show = 2'd3; send(4'h5, 1, 32'hFEDC_BA98); idle(11);
    // R5 capture off
    cfg_show = 2'd0; send(4'h5, 1, 32'hDEAD_BEEF); idle(3);
    // R7 R9 back-to-back 4-byte groups force stalls
    cfg_show = 2'd3;
    send(4'h5, 1, 32'h1111_2222);
    send(4'h5, 1, 32'h3333_4444);
    // R8 plain events during drain
    send(4'h3, 0, 32'h0); send(4'h4, 0, 32'h0);
    cfg_show = 2'd1;
    send(4'h5, 1, 32'h0000_5A6B);
    send(4'h5, 1, 32'h0000_C7D8);
    send(4'h5, 1, 32'h0000_0F10);
    idle(30);
    // R1 reset mid-stream
    cfg_show = 2'd3;
    send(4'h5, 1, 32'hA5A5_A5A5);
    @(negedge clk);
    mon_on = 1'b0;
    rst_n = 1'b0;
    #1;
    check(pst == 0 && ddata == 0 && stall == 0, "R1", {pst, ddata}, 0);
    exp_q.delete(); stage_q.delete(); stage_pst = 4'h0;
    @(negedge clk); rst_n = 1'b1;
    mon_on = 1'b1;
    idle(5);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule